// File: doc/BRIEF.md
# Selectable Pseudorandom Test Pattern Source

This block is the sending side of a bit error rate tester. It emits a serial test stream, one bit per accepted transfer, drawn from one of eight pattern codes: four maximal-length pseudorandom sequences, a 20-stage quasi-random sequence whose zero runs are capped, a programmable repeating word, and two codes that are not implemented and send a steady one. A downstream line interface takes the bits.

The host chooses a pattern code and a repeat word, then raises the load control. Only the low-to-high edge of that control restarts the source. At that edge the pattern code and the repeat word are captured, the shift register is filled with ones, the zero-run count is cleared and the word position goes back to its most significant bit. The invert control is applied to the output bit at all times.

The output is a stream with valid and ready. `bit_valid` goes high on the first clock after reset and then stays high. A bit is taken on each clock where valid and ready are both high, and the source then moves to its next bit. While ready is low the bit before inversion is held. A load edge takes priority over a transfer: in that cycle the source restarts and does not advance.

Top module: `prbs_gen_top`

## Requirements
- R1: After reset the source behaves as if code 000 had been loaded with an all-ones seed. The first seven accepted bits are therefore 1.
- R2: Code 000 produces the sequence of x^7+x^6+1. The state is shifted left, the new low bit is the XOR of stages 7 and 6, and the output is stage 7. The sequence repeats every 127 bits and the state is never all zero.
- R3: Codes 001, 111 and 010 use the same scheme with x^11+x^9+1, x^9+x^5+1 and x^15+x^14+1.
- R4: Code 011 uses x^20+x^17+1. When the raw bit is 0 and ZERO_LIMIT zeros have just been sent, the output is forced to 1. No more than ZERO_LIMIT consecutive zeros (before inversion) are ever sent.
- R5: Code 100 sends the captured repeat word MSB first and wraps from the LSB back to the MSB.
- R6: Codes 101 and 110 send a constant 1.
- R7: A rising edge of `load_ctl` restarts the source. Holding it high does not reload. Changing `pat_sel` or `rep_word` without an edge has no effect on the stream.
- R8: When `invert_ctl` is 1, `bit_data` is the complement of the pattern bit. When it is 0, `bit_data` is the pattern bit.
- R9: The source advances only on a transfer (valid and ready both high). With ready low, the bit before inversion stays stable.
- R10: `bit_valid` is 0 during reset and 1 from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_sel | input | 3 | Pattern code, captured on a load edge |
| load_ctl | input | 1 | Restart control, acts on its rising edge |
| invert_ctl | input | 1 | Complements the output bit |
| rep_word | input | WORD_W | Repeat word, captured on a load edge |
| bit_ready | input | 1 | Downstream accepts the current bit |
| bit_valid | output | 1 | Current bit is available |
| bit_data | output | 1 | Serial test bit |

## Verification
The bench builds the block with WORD_W = 12 and ZERO_LIMIT = 4. The short word makes wrap-around show up after twelve transfers. A run cap of four zeros is reached many times within a few thousand quasi-random bits, which brings the forcing path into reach. With the default cap of fourteen, a 2^20-1 sequence only rarely reaches that run length. Every other mode is independent of these parameters and runs in its real form.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int LFSR_W = 20;

  typedef enum logic [2:0] {
    PAT_P7    = 3'b000,
    PAT_P11   = 3'b001,
    PAT_P15   = 3'b010,
    PAT_QRS   = 3'b011,
    PAT_WORD  = 3'b100,
    PAT_ALTW  = 3'b101,
    PAT_FIX55 = 3'b110,
    PAT_P9    = 3'b111
  } pat_e;

  typedef struct packed {
    logic [LFSR_W-1:0] top;  // output stage
    logic [LFSR_W-1:0] fbm;  // stages XORed into feedback
  } lfsr_cfg_t;

  function automatic lfsr_cfg_t cfg_for(pat_e m);
    lfsr_cfg_t c;
    int n;
    int t;
    case (m)
      PAT_P9:  begin n = 9;  t = 5;  end
      PAT_P11: begin n = 11; t = 9;  end
      PAT_P15: begin n = 15; t = 14; end
      PAT_QRS: begin n = 20; t = 17; end
      default: begin n = 7;  t = 6;  end
    endcase
    c.top = LFSR_W'(1) << (n - 1);
    c.fbm = c.top | (LFSR_W'(1) << (t - 1));
    return c;
  endfunction

  function automatic logic is_lfsr(pat_e m);
    return (m == PAT_P7) || (m == PAT_P9) || (m == PAT_P11) ||
           (m == PAT_P15) || (m == PAT_QRS);
  endfunction
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int W = prbs_pkg::LFSR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         step,
  input  logic [W-1:0] top_mask,
  input  logic [W-1:0] fb_mask,
  output logic         out_bit
);
  logic [W-1:0] st;
  logic [W-1:0] keep;
  logic         fb;

  always_comb begin
    keep    = top_mask | (top_mask - W'(1));
    fb      = ^(st & fb_mask);
    out_bit = |(st & top_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= '1;
    else if (seed) st <= '1;
    else if (step) st <= {st[W-2:0], fb} & keep;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st & keep) != '0); // R2
endmodule

// File: rtl/prbs_zero_guard.sv
module prbs_zero_guard #(
  parameter int LIMIT = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic en,
  input  logic raw,
  output logic out_bit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] zrun;

  assign out_bit = raw | (en && (zrun == LIM_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          zrun <= '0;
    else if (clr)        zrun <= '0;
    else if (step && en) zrun <= out_bit ? '0 : zrun + CW'(1);
  end

  AST_ZERO_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= LIM_C); // R4
endmodule

// File: rtl/prbs_word_rot.sv
module prbs_word_rot #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              step,
  output logic              out_bit
);
  localparam int IW = $clog2(WORD_W);
  localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     pos;

  assign out_bit = word_q[LAST - pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos    <= '0;
    end else if (load) begin
      word_q <= word;
      pos    <= '0;
    end else if (step) begin
      pos <= (pos == LAST) ? '0 : pos + IW'(1);
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST); // R5
endmodule

// File: rtl/prbs_gen_top.sv
module prbs_gen_top
  import prbs_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ZERO_LIMIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pat_sel,
  input  logic              load_ctl,
  input  logic              invert_ctl,
  input  logic [WORD_W-1:0] rep_word,
  input  logic              bit_ready,
  output logic              bit_valid,
  output logic              bit_data
);
  logic      load_q;
  logic      valid_q;
  pat_e      mode_q;
  logic      ld;
  logic      step;
  lfsr_cfg_t cfg;
  logic      lfsr_bit;
  logic      guard_bit;
  logic      word_bit;
  logic      pat_bit;

  assign ld   = load_ctl & ~load_q;
  assign step = valid_q & bit_ready & ~ld;
  assign cfg  = cfg_for(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      valid_q <= 1'b0;
      mode_q  <= PAT_P7;
    end else begin
      load_q  <= load_ctl;
      valid_q <= 1'b1;
      if (ld) mode_q <= pat_e'(pat_sel);
    end
  end

  prbs_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (ld),
    .step     (step && is_lfsr(mode_q)),
    .top_mask (cfg.top),
    .fb_mask  (cfg.fbm),
    .out_bit  (lfsr_bit)
  );

  prbs_zero_guard #(.LIMIT(ZERO_LIMIT)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ld),
    .step    (step),
    .en      (mode_q == PAT_QRS),
    .raw     (lfsr_bit),
    .out_bit (guard_bit)
  );

  prbs_word_rot #(.WORD_W(WORD_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .word    (rep_word),
    .step    (step && (mode_q == PAT_WORD)),
    .out_bit (word_bit)
  );

  always_comb begin
    case (mode_q)
      PAT_QRS:             pat_bit = guard_bit;
      PAT_WORD:            pat_bit = word_bit;
      PAT_ALTW, PAT_FIX55: pat_bit = 1'b1;
      default:             pat_bit = lfsr_bit;
    endcase
  end

  assign bit_valid = valid_q;
  assign bit_data  = pat_bit ^ invert_ctl;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !bit_ready && !ld) |=> $stable(pat_bit)); // R9
  AST_MODE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(mode_q)); // R7
  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q); // R10
endmodule

// File: tb/tb_prbs_gen_top.sv
module tb_prbs_gen_top;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 12;
  localparam int ZL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    pat_sel = 3'b000;
  logic          load_ctl = 1'b0;
  logic          invert_ctl = 1'b0;
  logic [WB-1:0] rep_word = '0;
  logic          bit_ready = 1'b0;
  logic          bit_valid;
  logic          bit_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic  expq[$];
  string tagq[$];

  // reference model
  logic [2:0]    m_mode;
  logic [19:0]   m_st;
  int            m_z;
  logic [WB-1:0] m_word;
  int            m_idx;
  int            qrs_run = 0;
  int            qrs_max = 0;

  prbs_gen_top #(.WORD_W(WB), .ZERO_LIMIT(ZL)) dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .load_ctl(load_ctl),
    .invert_ctl(invert_ctl), .rep_word(rep_word), .bit_ready(bit_ready),
    .bit_valid(bit_valid), .bit_data(bit_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int len_of(logic [2:0] m);
    case (m)
      3'b001: return 11;
      3'b010: return 15;
      3'b011: return 20;
      3'b111: return 9;
      default: return 7;
    endcase
  endfunction

  function automatic int tap_of(logic [2:0] m);
    case (m)
      3'b001: return 9;
      3'b010: return 14;
      3'b011: return 17;
      3'b111: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic m_bit();
    case (m_mode)
      3'b100: return m_word[WB-1-m_idx];
      3'b101, 3'b110: return 1'b1;
      3'b011: return m_st[19] | (m_z == ZL);
      default: return m_st[len_of(m_mode)-1];
    endcase
  endfunction

  task automatic m_load(input logic [2:0] m, input logic [WB-1:0] w);
    m_mode = m; m_st = '1; m_z = 0; m_word = w; m_idx = 0;
  endtask

  task automatic m_adv();
    logic b;
    logic fb;
    b = m_bit();
    if (m_mode == 3'b100) begin
      m_idx = (m_idx + 1) % WB;
    end else if (m_mode != 3'b101 && m_mode != 3'b110) begin
      fb = m_st[len_of(m_mode)-1] ^ m_st[tap_of(m_mode)-1];
      m_st = {m_st[18:0], fb};
      if (m_mode == 3'b011) m_z = b ? 0 : m_z + 1;
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle, pushes the expected bit
  task automatic drive(input logic rdy, input string tag);
    bit_ready = rdy;
    expq.push_back(m_bit() ^ invert_ctl);
    tagq.push_back(tag);
    if (rdy) m_adv();
    @(posedge clk); #2;
  endtask

  task automatic run(input int n, input int stall_mod, input string tag);
    for (int i = 0; i < n; i++)
      drive((stall_mod == 0) || ((i % stall_mod) != 0), tag);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [WB-1:0] w);
    pat_sel = m; rep_word = w; load_ctl = 1'b1; bit_ready = 1'b0;
    @(posedge clk); #2;
    load_ctl = 1'b0;
    m_load(m, w);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (expq.size() > 0) begin
      logic e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(t, bit_data, e);
      if (t == "R4" && bit_ready) begin
        qrs_run = bit_data ? 0 : qrs_run + 1;
        if (qrs_run > qrs_max) qrs_max = qrs_run;
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    m_load(3'b000, '0);
    repeat (4) @(posedge clk);
    #2;
    check("R10", bit_valid, 1'b0);            // R10 low in reset
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R10", bit_valid, 1'b1);            // R10 high after reset
    run(7, 0, "R1");                          // R1 seven ones
    run(300, 0, "R2");                        // R2 wraps past 127
    do_load(3'b001, '0); run(200, 3, "R3");   // R3 with stalls (R9)
    do_load(3'b010, '0); run(120, 0, "R3");
    do_load(3'b111, '0); run(120, 4, "R9");
    do_load(3'b011, '0); run(3000, 0, "R4");
    check("R4", qrs_max == ZL, 1'b1);         // R4 cap reached, not exceeded
    do_load(3'b100, 12'hA5C); run(40, 5, "R5");
    rep_word = 12'h3F0; pat_sel = 3'b000;     // R7 no edge: ignored
    run(30, 0, "R7");
    do_load(3'b101, '0); run(16, 0, "R6");
    do_load(3'b110, '0); run(16, 0, "R6");
    invert_ctl = 1'b1; run(8, 0, "R8");
    // R7 hold load high: no second reload
    pat_sel = 3'b000; load_ctl = 1'b1; bit_ready = 1'b0;
    @(posedge clk); #2;
    m_load(3'b000, rep_word);
    pat_sel = 3'b100;
    run(20, 0, "R7");
    load_ctl = 1'b0; run(20, 0, "R7");
    invert_ctl = 1'b0; run(20, 2, "R8");
    invert_ctl = 1'b1; run(20, 0, "R8");
    invert_ctl = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule